// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block sits beside a processor's microcode state machine and decides what happens when an instruction ends. In the same clock in which the instruction finishes, it picks one of four actions from the pending-interrupt, external-source and halt inputs. The actions are: request a normal opcode fetch, stop in a low-power idle state, run an internally vectored acknowledge, or run an external acknowledge. Choosing here costs no extra clock. The chosen bus activity starts on the very next edge.

For an external source, the sequencer runs an acknowledge read at the all-ones address with the I/O-select line high and the acknowledge strobe low, and latches the byte the device returns. If that byte is a CALL opcode, two shorter acknowledge reads follow and collect the target address, low byte first. If the byte is a restart opcode, the target is derived from the opcode. For an internal source, a dummy cycle runs with the bus floated, and the source's fixed vector is loaded. Both kinds of acknowledge copy the old program counter to a temp register so that the microcode can push it later. A sticky auto-vector flag tells the shared microcode not to decode the instruction latch after an internal acknowledge.

Top module: `irq_ack_seq`

## Requirements
- R1: While running, `fetch_req` is high in the same clock as `instr_done` only when neither `irq_pend` nor `halt_req` is high. A pending interrupt takes priority over a halt request. When an interrupt is pending at the boundary, the acknowledge starts on the next clock: the external form when `irq_ext` is 1, the internal form when it is 0.
- R2: While an instruction is in progress (`instr_done` low, not halted), a pending interrupt causes no bus activity. `inta_n` stays 1, and `iom_o` and `float_o` stay 0.
- R3: The external opcode cycle lasts 6 clocks when `rdy` is high. Throughout it, `addr_o` is all ones and `iom_o` is 1. `inta_n` is low on its 2nd and 3rd clocks only. `din` is latched into `ilat_o` on the 3rd clock.
- R4: In any acknowledge read cycle, each clock in which `rdy` is low at the 3rd position holds the cycle there for one more clock.
- R5: When the latched opcode is 8'hCD, two 3-clock acknowledge reads follow, supplying the low byte and then the high byte. `pc_we` fires on the last clock of the second read, with `pc_val` = {high, low}.
- R6: An opcode of the form 2'b11,nnn,3'b111 loads `pc_val` = n×8 on the 6th clock of the opcode cycle. Opcode 8'hCB loads 16'h0040. Any other non-CALL opcode loads nothing. All upper address bits of a generated vector are zero.
- R7: The internal acknowledge lasts 6 clocks whatever `rdy` does, with `float_o` high and `inta_n` high. On its 6th clock it loads the vector selected by `irq_src`: 0 gives 16'h0024, 1 gives 16'h003C, 2 gives 16'h0034, and 3 gives 16'h002C.
- R8: On the first clock of either acknowledge, `temp_we` is high and `temp_val` equals `pc_cur`. `temp_we` and `pc_we` are never high together.
- R9: `avec_o` goes high from the first clock of an internal acknowledge and stays high through later cycles. It drops on the clock after `fetch_req` and is 0 after reset.
- R10: A halt request at a boundary with nothing pending enters an idle state with `float_o` high, which lasts until an interrupt is pending or reset is applied. A pending interrupt in that state starts the acknowledge on the next clock.
- R11: `done_o` is high on exactly the final clock of each acknowledge sequence, and the sequencer is back in the running state on the clock after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Last state of the current instruction |
| halt_req | input | 1 | Ending instruction is a halt |
| irq_pend | input | 1 | An enabled interrupt is pending |
| irq_ext | input | 1 | The pending source is the external request line |
| irq_src | input | 2 | Internal source: 0 trap, 1 high, 2 mid, 3 low restart |
| rdy | input | 1 | Bus ready; low inserts wait clocks |
| din | input | 8 | Data bus input |
| pc_cur | input | ADDR_W | Current program counter |
| fetch_req | output | 1 | Request a normal opcode fetch |
| addr_o | output | ADDR_W | Acknowledge address |
| iom_o | output | 1 | I/O-select line |
| inta_n | output | 1 | Acknowledge strobe, active low |
| float_o | output | 1 | Request to tri-state all bus pins |
| ilat_o | output | 8 | Instruction latch |
| pc_we | output | 1 | Program counter load |
| pc_val | output | ADDR_W | Program counter load value |
| temp_we | output | 1 | Temp register load |
| temp_val | output | ADDR_W | Temp register load value |
| avec_o | output | 1 | Auto-vector flag |
| done_o | output | 1 | Final clock of an acknowledge sequence |

## Verification
The hardest states to reach are the ones stacked behind earlier events. An internal acknowledge must be left unfollowed by a fetch so the flag is still set. The halt idle must be woken by an interrupt rather than by reset. The opcode read must be stretched by wait clocks at exactly the sampling position. The stimulus reaches these by holding `instr_done` off after an acknowledge, by raising `irq_pend` only after several idle clocks, and by dropping `rdy` for two clocks at the third position. Each expected program counter and temp load is queued before the sequence starts and matched against the loads as they appear.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_FETCH = 2'd1,
        ACT_AVEC  = 2'd2,
        ACT_IACK  = 2'd3
    } next_act_e;

    typedef enum logic [2:0] {
        SQ_RUN   = 3'd0,
        SQ_HALT  = 3'd1,
        SQ_AVEC  = 3'd2,
        SQ_IA_OP = 3'd3,
        SQ_IA_LO = 3'd4,
        SQ_IA_HI = 3'd5
    } seq_st_e;

    typedef enum logic [1:0] {
        SRC_TRAP = 2'd0,
        SRC_HI   = 2'd1,
        SRC_MID  = 2'd2,
        SRC_LO   = 2'd3
    } int_src_e;

    localparam logic [7:0] OP_CALL  = 8'hCD;
    localparam logic [7:0] OP_RSTU  = 8'hCB;
    localparam logic [7:0] VEC_RSTU = 8'h40;

    function automatic logic op_is_restart(input logic [7:0] op);
        return (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
    endfunction

    function automatic logic op_has_vec(input logic [7:0] op);
        return op_is_restart(op) || (op == OP_RSTU);
    endfunction

    function automatic logic [7:0] op_vec(input logic [7:0] op);
        logic [7:0] v;
        if (op_is_restart(op))
            v = {2'b00, op[5:3], 3'b000};
        else if (op == OP_RSTU)
            v = VEC_RSTU;
        else
            v = 8'h00;
        return v;
    endfunction

    function automatic logic [7:0] src_vec(input int_src_e s);
        logic [7:0] v;
        case (s)
            SRC_TRAP: v = 8'h24;
            SRC_HI:   v = 8'h3C;
            SRC_MID:  v = 8'h34;
            default:  v = 8'h2C;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/irq_next_sel.sv
module irq_next_sel
    import irq_ack_pkg::*;
(
    input  logic      poll_en,
    input  logic      pend,
    input  logic      ext,
    input  logic      halt,
    output next_act_e act,
    output logic      fetch
);
    // Pure combinational chooser: evaluated inside the boundary clock itself.
    always_comb begin
        if (pend)
            act = ext ? ACT_IACK : ACT_AVEC;
        else if (halt)
            act = ACT_IDLE;
        else
            act = ACT_FETCH;
    end

    assign fetch = poll_en && (act == ACT_FETCH);
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
    import irq_ack_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [7:0]        op,
    input  int_src_e          src,
    input  logic [7:0]        lo_byte,
    input  logic [7:0]        hi_byte,
    output logic              op_ok,
    output logic [ADDR_W-1:0] op_addr,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] call_addr
);
    localparam int PAD_W  = ADDR_W - 8;
    localparam int CALL_W = (ADDR_W < 16) ? ADDR_W : 16;

    logic [15:0] call16;
    assign call16 = {hi_byte, lo_byte};
    assign op_ok  = op_has_vec(op);

    generate
        if (PAD_W > 0) begin : g_pad
            assign op_addr  = {{PAD_W{1'b0}}, op_vec(op)};
            assign src_addr = {{PAD_W{1'b0}}, src_vec(src)};
        end else begin : g_nopad
            assign op_addr  = op_vec(op);
            assign src_addr = src_vec(src);
        end
        if (ADDR_W > 16) begin : g_cwide
            assign call_addr = {{(ADDR_W-16){1'b0}}, call16};
        end else begin : g_cnarrow
            assign call_addr = call16[CALL_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/irq_cyc_timer.sv
module irq_cyc_timer #(
    parameter int CNT_W    = 3,
    parameter int WAIT_IDX = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [CNT_W-1:0] len,
    input  logic             rdy,
    output logic [CNT_W-1:0] cnt,
    output logic             smp,
    output logic             last
);
    localparam logic [CNT_W-1:0] WPOS = CNT_W'(WAIT_IDX);

    logic adv;
    assign adv  = !((cnt == WPOS) && !rdy);
    assign smp  = active && (cnt == WPOS) && rdy;
    assign last = active && adv && (cnt == len - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !active || last)
            cnt <= '0;
        else if (adv)
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_ack_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int ACK_CLKS = 6,
    parameter int RD_CLKS  = 3,
    parameter int WAIT_POS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_done,
    input  logic              halt_req,
    input  logic              irq_pend,
    input  logic              irq_ext,
    input  logic [1:0]        irq_src,
    input  logic              rdy,
    input  logic [7:0]        din,
    input  logic [ADDR_W-1:0] pc_cur,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] addr_o,
    output logic              iom_o,
    output logic              inta_n,
    output logic              float_o,
    output logic [7:0]        ilat_o,
    output logic              pc_we,
    output logic [ADDR_W-1:0] pc_val,
    output logic              temp_we,
    output logic [ADDR_W-1:0] temp_val,
    output logic              avec_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(ACK_CLKS + 1);
    localparam logic [CNT_W-1:0] LEN_ACK = CNT_W'(ACK_CLKS);
    localparam logic [CNT_W-1:0] LEN_RD  = CNT_W'(RD_CLKS);
    localparam logic [CNT_W-1:0] STB_LO  = CNT_W'(1);
    localparam logic [CNT_W-1:0] STB_HI  = CNT_W'(WAIT_POS);

    seq_st_e   st_q, st_d;
    int_src_e  src_q;
    logic [7:0] ilat_q, lo_q;
    logic       avec_q;

    // Boundary decision
    logic      poll_en, halt_eff, sel_fetch;
    next_act_e act;

    assign poll_en  = ((st_q == SQ_RUN) && instr_done) || (st_q == SQ_HALT);
    assign halt_eff = (st_q == SQ_HALT) || halt_req;

    irq_next_sel u_sel (
        .poll_en (poll_en),
        .pend    (irq_pend),
        .ext     (irq_ext),
        .halt    (halt_eff),
        .act     (act),
        .fetch   (sel_fetch)
    );

    // Cycle timing
    logic             ia_st, cyc_active, tmr_rdy, smp, last;
    logic [CNT_W-1:0] cyc_len, cnt;

    assign ia_st      = (st_q == SQ_IA_OP) || (st_q == SQ_IA_LO) || (st_q == SQ_IA_HI);
    assign cyc_active = ia_st || (st_q == SQ_AVEC);
    assign cyc_len    = ((st_q == SQ_IA_LO) || (st_q == SQ_IA_HI)) ? LEN_RD : LEN_ACK;
    assign tmr_rdy    = rdy || (st_q == SQ_AVEC);

    irq_cyc_timer #(
        .CNT_W    (CNT_W),
        .WAIT_IDX (WAIT_POS)
    ) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .active (cyc_active),
        .len    (cyc_len),
        .rdy    (tmr_rdy),
        .cnt    (cnt),
        .smp    (smp),
        .last   (last)
    );

    // Vector generation
    logic              op_ok;
    logic [ADDR_W-1:0] op_addr, src_addr, call_addr;

    irq_vec_gen #(
        .ADDR_W (ADDR_W)
    ) u_vec (
        .op        (ilat_q),
        .src       (src_q),
        .lo_byte   (lo_q),
        .hi_byte   (din),
        .op_ok     (op_ok),
        .op_addr   (op_addr),
        .src_addr  (src_addr),
        .call_addr (call_addr)
    );

    // Next-state selection
    always_comb begin
        st_d = st_q;
        case (st_q)
            SQ_RUN, SQ_HALT: begin
                if (poll_en) begin
                    case (act)
                        ACT_IACK:  st_d = SQ_IA_OP;
                        ACT_AVEC:  st_d = SQ_AVEC;
                        ACT_IDLE:  st_d = SQ_HALT;
                        default:   st_d = SQ_RUN;
                    endcase
                end
            end
            SQ_AVEC:  if (last) st_d = SQ_RUN;
            SQ_IA_OP: if (last) st_d = (ilat_q == OP_CALL) ? SQ_IA_LO : SQ_RUN;
            SQ_IA_LO: if (last) st_d = SQ_IA_HI;
            SQ_IA_HI: if (last) st_d = SQ_RUN;
            default:  st_d = SQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_RUN;
            src_q  <= SRC_TRAP;
            ilat_q <= 8'h00;
            lo_q   <= 8'h00;
            avec_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (poll_en && (act == ACT_AVEC)) begin
                src_q  <= int_src_e'(irq_src);
                avec_q <= 1'b1;
            end else if (sel_fetch) begin
                avec_q <= 1'b0;
            end
            if ((st_q == SQ_IA_OP) && smp)
                ilat_q <= din;
            if ((st_q == SQ_IA_LO) && smp)
                lo_q <= din;
        end
    end

    // Register-file side effects
    logic op_load, av_load, call_load;
    assign op_load   = (st_q == SQ_IA_OP) && last && op_ok;
    assign av_load   = (st_q == SQ_AVEC) && last;
    assign call_load = (st_q == SQ_IA_HI) && last;

    always_comb begin
        pc_val = '0;
        if (op_load)
            pc_val = op_addr;
        else if (av_load)
            pc_val = src_addr;
        else if (call_load)
            pc_val = call_addr;
    end

    assign pc_we    = op_load || av_load || call_load;
    assign temp_we  = ((st_q == SQ_IA_OP) || (st_q == SQ_AVEC)) && (cnt == '0);
    assign temp_val = pc_cur;

    // Bus-side outputs
    assign fetch_req = sel_fetch;
    assign iom_o     = ia_st;
    assign addr_o    = ia_st ? {ADDR_W{1'b1}} : '0;
    assign inta_n    = !(ia_st && (cnt >= STB_LO) && (cnt <= STB_HI));
    assign float_o   = (st_q == SQ_AVEC) || (st_q == SQ_HALT);
    assign ilat_o    = ilat_q;
    assign avec_o    = avec_q;
    assign done_o    = last && (((st_q == SQ_IA_OP) && (ilat_q != OP_CALL)) ||
                                (st_q == SQ_AVEC) || (st_q == SQ_IA_HI));
endmodule

// File: rtl/irq_ack_seq_chk.sv
module irq_ack_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rdy,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] addr_o,
    input logic              iom_o,
    input logic              inta_n,
    input logic              float_o,
    input logic              pc_we,
    input logic              temp_we,
    input logic              avec_o,
    input logic              done_o
);
    AST_STROBE_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        !inta_n |-> (iom_o && (addr_o == {ADDR_W{1'b1}}))); // R3

    AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (rst)
        float_o |-> (inta_n && !iom_o)); // R7

    AST_FETCH_DROPS_AVEC: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> !avec_o); // R9

    AST_AVEC_RISES_FLOATED: assert property (@(posedge clk) disable iff (rst)
        $rose(avec_o) |-> float_o); // R9

    AST_TEMP_PC_APART: assert property (@(posedge clk) disable iff (rst)
        !(temp_we && pc_we)); // R8

    AST_FETCH_ONLY_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> (inta_n && !float_o && !iom_o && !done_o)); // R1

    AST_DONE_RETURNS: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (inta_n && !float_o && !iom_o)); // R11

    AST_WAIT_KEEPS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!inta_n && !rdy && !float_o && $past(!inta_n)) |=> !inta_n); // R4
endmodule

bind irq_ack_seq irq_ack_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_ack_seq_tb_top.sv
module irq_ack_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    localparam int EV_TEMP  = 0;
    localparam int EV_PC    = 1;
    localparam int EV_FETCH = 2;

    typedef struct {
        int          kind;
        logic [15:0] val;
        string       req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          instr_done = 1'b0, halt_req = 1'b0, irq_pend = 1'b0, irq_ext = 1'b0;
    logic [1:0]    irq_src = 2'd0;
    logic          rdy = 1'b1;
    logic [7:0]    din = 8'h00;
    logic [AW-1:0] pc_cur = '0;
    logic          fetch_req, iom_o, inta_n, float_o, pc_we, temp_we, avec_o, done_o;
    logic [AW-1:0] addr_o, pc_val, temp_val;
    logic [7:0]    ilat_o;

    int   tests = 0;
    int   fails = 0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ack_seq #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .instr_done(instr_done), .halt_req(halt_req),
        .irq_pend(irq_pend), .irq_ext(irq_ext), .irq_src(irq_src), .rdy(rdy),
        .din(din), .pc_cur(pc_cur), .fetch_req(fetch_req), .addr_o(addr_o),
        .iom_o(iom_o), .inta_n(inta_n), .float_o(float_o), .ilat_o(ilat_o),
        .pc_we(pc_we), .pc_val(pc_val), .temp_we(temp_we), .temp_val(temp_val),
        .avec_o(avec_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [15:0] val, input string req);
        exp_t e;
        e.kind = kind; e.val = val; e.req = req;
        q.push_back(e);
    endtask

    task automatic match(input int kind, input logic [15:0] val);
        exp_t e;
        if (q.size() == 0) begin
            chk(1'b0, "unexpected-event", kind, 32'hFFFF);
        end else begin
            e = q.pop_front();
            chk((e.kind == kind) && (e.val == val), e.req, {kind[15:0], val}, {e.kind[15:0], e.val});
        end
    endtask

    // Scoreboard monitor: every load or fetch request must match the queue head
    always @(negedge clk) begin
        if (!rst) begin
            if (temp_we)   match(EV_TEMP, temp_val);
            if (pc_we)     match(EV_PC, pc_val);
            if (fetch_req) match(EV_FETCH, 16'h0000);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drained(input string req);
        chk(q.size() == 0, req, q.size(), 0);
    endtask

    // Runs one acknowledge sequence from its first clock; returns its length.
    task automatic run_ack(input string req, input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input int hold_at, input int hold_n,
                           input bit ext, output int dur);
        dur = 0;
        for (int i = 0; i < 40; i++) begin
            din = (i < 6) ? b0 : ((i < 9) ? b1 : b2);
            rdy = !((i >= hold_at) && (i < hold_at + hold_n));
            @(negedge clk);
            if (ext && (hold_n == 0) && (i < 6)) begin
                chk(inta_n == !((i == 1) || (i == 2)), "R3 strobe", inta_n, !((i == 1) || (i == 2)));
                chk(iom_o && (addr_o == 16'hFFFF), "R3 addr/iom", {iom_o, addr_o}, 17'h1FFFF);
            end
            if (!ext) begin
                chk(float_o && inta_n, "R7 floated", {float_o, inta_n}, 2'b11);
                chk(avec_o == 1'b1, "R9 avec set", avec_o, 1);
            end
            if (done_o) begin
                dur = i + 1;
                break;
            end
            step();
        end
        rdy = 1'b1;
        chk(dur != 0, {req, " R11 done"}, dur, 1);
        step();
        @(negedge clk);
        chk(inta_n && !float_o && !iom_o, "R11 back to run", {inta_n, float_o, iom_o}, 3'b100);
    endtask

    task automatic start_irq(input bit ext, input logic [1:0] src, input logic [15:0] pc, input bit hr);
        step();
        pc_cur = pc; irq_pend = 1'b1; irq_ext = ext; irq_src = src;
        instr_done = 1'b1; halt_req = hr;
        step();
        instr_done = 1'b0; irq_pend = 1'b0; halt_req = 1'b0;
    endtask

    initial begin
        int dur;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // Reset state
        chk(!fetch_req && inta_n && !iom_o && !float_o, "R1 reset bus", {fetch_req, inta_n, iom_o, float_o}, 4'b0100);
        chk(!avec_o && !done_o && !pc_we && ilat_o == 8'h00, "R9 reset flag", {avec_o, done_o, pc_we, ilat_o}, 0);

        // R1: plain fetch chosen in the boundary clock
        step();
        instr_done = 1'b1;
        push(EV_FETCH, 16'h0000, "R1 fetch");
        @(negedge clk);
        chk(fetch_req == 1'b1, "R1 same-clock fetch", fetch_req, 1);
        step();
        instr_done = 1'b0;
        @(negedge clk);
        chk(!fetch_req && inta_n && !float_o, "R1 no extra", {fetch_req, inta_n, float_o}, 3'b010);
        drained("R1 fetch drained");

        // R2: pending ignored mid-instruction
        step();
        irq_pend = 1'b1; irq_ext = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(inta_n && !iom_o && !float_o, "R2 ignored", {inta_n, iom_o, float_o}, 3'b100);
            step();
        end
        irq_pend = 1'b0;

        // R3/R6/R8: external acknowledge returning a restart 5 opcode
        push(EV_TEMP, 16'h1111, "R8 temp ext");
        push(EV_PC, 16'h0028, "R6 restart 5");
        start_irq(1'b1, 2'd0, 16'h1111, 1'b0);
        run_ack("R3", 8'hEF, 8'h00, 8'h00, 0, 0, 1'b1, dur);
        chk(dur == 6, "R3 length", dur, 6);
        chk(ilat_o == 8'hEF, "R3 latch", ilat_o, 8'hEF);
        drained("R6 restart drained");

        // R4: two wait clocks at the sampling position
        push(EV_TEMP, 16'h2222, "R8 temp wait");
        push(EV_PC, 16'h0038, "R4 restart 7");
        start_irq(1'b1, 2'd0, 16'h2222, 1'b0);
        run_ack("R4", 8'hFF, 8'h00, 8'h00, 2, 2, 1'b1, dur);
        chk(dur == 8, "R4 stretched", dur, 8);
        drained("R4 drained");

        // R5: CALL with a two-byte target
        push(EV_TEMP, 16'h3333, "R8 temp call");
        push(EV_PC, 16'h1234, "R5 call target");
        start_irq(1'b1, 2'd0, 16'h3333, 1'b0);
        run_ack("R5", 8'hCD, 8'h34, 8'h12, 0, 0, 1'b1, dur);
        chk(dur == 12, "R5 length", dur, 12);
        drained("R5 drained");

        // R6: undefined restart opcode and a plain opcode
        push(EV_TEMP, 16'h5555, "R8 temp rstu");
        push(EV_PC, 16'h0040, "R6 undefined restart");
        start_irq(1'b1, 2'd0, 16'h5555, 1'b0);
        run_ack("R6", 8'hCB, 8'h00, 8'h00, 0, 0, 1'b1, dur);
        chk(dur == 6, "R6 rstu length", dur, 6);
        push(EV_TEMP, 16'h6666, "R8 temp other");
        start_irq(1'b1, 2'd0, 16'h6666, 1'b0);
        run_ack("R6", 8'h00, 8'h00, 8'h00, 0, 0, 1'b1, dur);
        chk(dur == 6 && ilat_o == 8'h00, "R6 no load", {dur[7:0], ilat_o}, 16'h0600);
        drained("R6 drained");

        // R7/R1: trap beats a simultaneous halt request; rdy low is ignored
        push(EV_TEMP, 16'h4444, "R8 temp trap");
        push(EV_PC, 16'h0024, "R7 trap vector");
        start_irq(1'b0, 2'd0, 16'h4444, 1'b1);
        run_ack("R7", 8'h00, 8'h00, 8'h00, 2, 3, 1'b0, dur);
        chk(dur == 6, "R7 length", dur, 6);
        chk(avec_o == 1'b1, "R9 avec held", avec_o, 1);
        drained("R7 trap drained");

        // R9: fetch request drops the flag
        step();
        instr_done = 1'b1;
        push(EV_FETCH, 16'h0000, "R9 fetch");
        step();
        instr_done = 1'b0;
        @(negedge clk);
        chk(avec_o == 1'b0, "R9 cleared by fetch", avec_o, 0);

        // R7: remaining internal sources
        for (int s = 1; s < 4; s++) begin
            logic [15:0] v;
            v = (s == 1) ? 16'h003C : ((s == 2) ? 16'h0034 : 16'h002C);
            push(EV_TEMP, 16'h7000 + 16'(s), "R8 temp src");
            push(EV_PC, v, "R7 source vector");
            start_irq(1'b0, 2'(s), 16'h7000 + 16'(s), 1'b0);
            run_ack("R7", 8'h00, 8'h00, 8'h00, 0, 0, 1'b0, dur);
            chk(dur == 6, "R7 src length", dur, 6);
        end
        drained("R7 drained");

        // R10: halt idle, then woken by a pending interrupt
        step();
        instr_done = 1'b1; halt_req = 1'b1;
        step();
        instr_done = 1'b0; halt_req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(float_o && !fetch_req, "R10 halted", {float_o, fetch_req}, 2'b10);
            step();
        end
        irq_pend = 1'b1; irq_ext = 1'b0; irq_src = 2'd2; pc_cur = 16'h8888;
        push(EV_TEMP, 16'h8888, "R10 wake temp");
        push(EV_PC, 16'h0034, "R10 wake vector");
        step();
        irq_pend = 1'b0;
        run_ack("R10", 8'h00, 8'h00, 8'h00, 0, 0, 1'b0, dur);
        chk(dur == 6, "R10 wake length", dur, 6);
        drained("R10 drained");

        // R10/R9: reset leaves halt and clears the flag
        step();
        instr_done = 1'b1; halt_req = 1'b1;
        step();
        instr_done = 1'b0; halt_req = 1'b0;
        @(negedge clk);
        chk(float_o == 1'b1, "R10 halted again", float_o, 1);
        step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        @(negedge clk);
        chk(!float_o && !avec_o, "R10 reset wakes", {float_o, avec_o}, 0);

        repeat (2) step();
        drained("final drained");
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog (all) actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule